// File: doc/BRIEF.md
# Drive Level Adjust Calculator

During link training a receiver asks for a voltage-swing level and a pre-emphasis level on each of its lanes. This block merges those per-lane requests into one transmitter drive setting. It looks only at the lanes that are active. It takes the strongest swing and the strongest pre-emphasis that any of those lanes asked for. It then limits both against what the transmitter can deliver and returns one training-set byte, copied into every lane slot. Two flags in the byte tell the training loop that swing or pre-emphasis has hit its ceiling, so the loop can stop asking for more.

Pre-emphasis is settled first, because it sets the swing budget: the more pre-emphasis is used, the less swing headroom is left. The effective swing ceiling is the smaller of the transmitter's own swing ceiling and the limit that the chosen pre-emphasis imposes.

The block holds a small two-state controller. `ST_IDLE` waits for a strobe. `ST_REPORT` is the cycle in which a fresh result is shown with `done` high. The transitions are:

- `start` in `ST_IDLE` moves the controller to `ST_REPORT`.
- `start` in `ST_REPORT` keeps it in `ST_REPORT`, for back-to-back requests.
- No `start` in `ST_REPORT` returns it to `ST_IDLE`.

Top module: `drive_level_adjust`

## Requirements
- R1: While `rst_n` is low, every bit of `lane_set` is 0 and `done` is 0. This also holds for a reset applied after results have been produced.
- R2: A lane whose index is equal to or above `lane_cnt` has no effect on the result. With `lane_cnt` 0, both merged levels are 0.
- R3: The merged swing is the largest swing request among active lanes, and the merged pre-emphasis is the largest pre-emphasis request among active lanes. Lane i uses bits [2i+1:2i] of `swing_req` and of `emph_req`.
- R4: If the merged pre-emphasis is greater than or equal to `tx_emph_ceil`, the pre-emphasis field becomes `tx_emph_ceil` and the pre-emphasis-max flag is set. Otherwise the flag is clear and the level passes through.
- R5: The swing limit that the final pre-emphasis level imposes is 3 minus that level: pre-emphasis 0 allows swing 3, 1 allows 2, 2 allows 1, and 3 allows 0.
- R6: The effective swing ceiling is the smaller of `tx_swing_ceil` and the R5 limit.
- R7: If the merged swing is greater than or equal to the effective ceiling, the swing field becomes that ceiling and the swing-max flag is set. Otherwise the flag is clear and the swing passes through.
- R8: All four byte slots of `lane_set` carry the same byte, whatever the value of `lane_cnt`.
- R9: The byte layout is: swing in bits [1:0], swing-max flag in bit 2, pre-emphasis in bits [4:3], pre-emphasis-max flag in bit 5, and bits [7:6] always 0. Slot k sits in `lane_set[8k+7:8k]`.
- R10: A result computed from the inputs present with `start` appears on `lane_set` at the next clock edge. At that same edge `done` is high for exactly one cycle per strobe. Strobes on consecutive cycles give `done` on consecutive cycles.
- R11: Without `start`, `lane_set` keeps its value and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Compute strobe, one cycle per request |
| lane_cnt | input | 3 | Number of active lanes, 0 to 4 |
| swing_req | input | 8 | Per-lane swing requests, 2 bits per lane |
| emph_req | input | 8 | Per-lane pre-emphasis requests, 2 bits per lane |
| tx_swing_ceil | input | 2 | Transmitter swing ceiling |
| tx_emph_ceil | input | 2 | Transmitter pre-emphasis ceiling |
| lane_set | output | 32 | Four training-set bytes, one per lane slot |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench places high requests on lanes above the active count. A design that compared against the lane count with an off-by-one error would let such a lane raise the merged level. It sweeps every pre-emphasis level against a generous transmitter swing ceiling to expose a wrong pre-emphasis-to-swing table. It also checks an exact-equality case, so a strict comparison instead of "at or above" would leave a max flag clear. Back-to-back strobes and idle gaps catch a `done` that is stretched or dropped, and a result that drifts while no strobe is present.

// File: rtl/dla_pkg.sv
package dla_pkg;

    localparam int LVL_W  = 2;
    localparam int BYTE_W = 8;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic [1:0] pad;
        logic       emph_max;
        lvl_t       emph;
        logic       swing_max;
        lvl_t       swing;
    } tset_t;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } st_t;

    // The swing budget shrinks as pre-emphasis grows: limit = 3 - emph.
    function automatic lvl_t swing_budget(input lvl_t emph);
        return lvl_t'(((1 << LVL_W) - 1) - int'(emph));
    endfunction

endpackage

// File: rtl/dla_lane_max.sv
module dla_lane_max
    import dla_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [CNT_W-1:0]       lane_cnt,
    input  logic [LANES*LVL_W-1:0] swing_req,
    input  logic [LANES*LVL_W-1:0] emph_req,
    output lvl_t                   max_swing,
    output lvl_t                   max_emph
);

    lvl_t masked_swing [LANES];
    lvl_t masked_emph  [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        logic active;
        assign active          = (CNT_W'(g) < lane_cnt);
        assign masked_swing[g] = active ? swing_req[g*LVL_W +: LVL_W] : '0;
        assign masked_emph[g]  = active ? emph_req[g*LVL_W +: LVL_W]  : '0;
    end

    always_comb begin
        max_swing = '0;
        max_emph  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (masked_swing[i] > max_swing) max_swing = masked_swing[i];
            if (masked_emph[i]  > max_emph)  max_emph  = masked_emph[i];
        end
    end

endmodule

// File: rtl/dla_clamp.sv
module dla_clamp
    import dla_pkg::*;
(
    input  lvl_t  req_swing,
    input  lvl_t  req_emph,
    input  lvl_t  tx_swing_ceil,
    input  lvl_t  tx_emph_ceil,
    output tset_t result
);

    lvl_t emph_final;
    logic emph_sat;
    lvl_t budget;
    lvl_t swing_ceil;

    always_comb begin
        emph_sat   = (req_emph >= tx_emph_ceil);
        emph_final = emph_sat ? tx_emph_ceil : req_emph;
        budget     = swing_budget(emph_final);
        swing_ceil = (tx_swing_ceil < budget) ? tx_swing_ceil : budget;

        result           = '0;
        result.emph      = emph_final;
        result.emph_max  = emph_sat;
        result.swing_max = (req_swing >= swing_ceil);
        result.swing     = result.swing_max ? swing_ceil : req_swing;
    end

endmodule

// File: rtl/dla_ctrl.sv
module dla_ctrl
    import dla_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic done
);

    st_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_REPORT;
            ST_REPORT: state_d = start ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load = start;
        done = (state_q == ST_REPORT);
    end

    p_done_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

endmodule

// File: rtl/drive_level_adjust.sv
module drive_level_adjust
    import dla_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        lane_cnt,
    input  logic [LANES*LVL_W-1:0]  swing_req,
    input  logic [LANES*LVL_W-1:0]  emph_req,
    input  logic [LVL_W-1:0]        tx_swing_ceil,
    input  logic [LVL_W-1:0]        tx_emph_ceil,
    output logic [LANES*BYTE_W-1:0] lane_set,
    output logic                    done
);

    lvl_t  max_swing, max_emph;
    tset_t next_set;
    logic  load;

    dla_lane_max #(.LANES(LANES), .CNT_W(CNT_W)) u_max (
        .lane_cnt  (lane_cnt),
        .swing_req (swing_req),
        .emph_req  (emph_req),
        .max_swing (max_swing),
        .max_emph  (max_emph)
    );

    dla_clamp u_clamp (
        .req_swing     (max_swing),
        .req_emph      (max_emph),
        .tx_swing_ceil (tx_swing_ceil),
        .tx_emph_ceil  (tx_emph_ceil),
        .result        (next_set)
    );

    dla_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .done  (done)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        tset_t slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    slot_q <= '0;
            else if (load) slot_q <= next_set;
        end
        assign lane_set[k*BYTE_W +: BYTE_W] = slot_q;
    end

    p_slots_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lane_set[BYTE_W-1:0] == lane_set[2*BYTE_W-1:BYTE_W]
        && lane_set[BYTE_W-1:0] == lane_set[LANES*BYTE_W-1 -: BYTE_W]);

    p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_set[7:6] == 2'b00);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(lane_set));

    p_swing_in_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(lane_set[1:0]) + int'(lane_set[4:3]) <= 3));

    p_emph_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (lane_set[5] |-> lane_set[4:3] == $past(tx_emph_ceil)));

    p_swing_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!lane_set[2] |-> lane_set[1:0] < $past(tx_swing_ceil)));

endmodule

// File: tb/sim_drive_level_adjust.sv
module sim_drive_level_adjust;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  lane_cnt = '0;
    logic [7:0]  swing_req = '0;
    logic [7:0]  emph_req = '0;
    logic [1:0]  tx_swing_ceil = '0;
    logic [1:0]  tx_emph_ceil = '0;
    logic [31:0] lane_set;
    logic        done;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_exp = '0;
    bit          finished = 0;

    always #2 clk = ~clk;

    drive_level_adjust u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
        .swing_req(swing_req), .emph_req(emph_req),
        .tx_swing_ceil(tx_swing_ceil), .tx_emph_ceil(tx_emph_ceil),
        .lane_set(lane_set), .done(done)
    );

    function automatic logic [31:0] model(input logic [2:0] cnt, input logic [7:0] sw,
                                          input logic [7:0] em, input logic [1:0] vc,
                                          input logic [1:0] pc);
        int v = 0, p = 0, lim, eff;
        bit vf, pf;
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            if (i < int'(cnt)) begin
                if (int'(sw[2*i +: 2]) > v) v = int'(sw[2*i +: 2]);
                if (int'(em[2*i +: 2]) > p) p = int'(em[2*i +: 2]);
            end
        end
        pf = (p >= int'(pc));
        if (pf) p = int'(pc);
        case (p)
            0: lim = 3;
            1: lim = 2;
            2: lim = 1;
            default: lim = 0;
        endcase
        eff = (int'(vc) < lim) ? int'(vc) : lim;
        vf = (v >= eff);
        if (vf) v = eff;
        b = {2'b00, pf, p[1:0], vf, v[1:0]};
        return {b, b, b, b};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one strobe and pushes the expected result.
    task automatic issue(input string tag, input logic [2:0] cnt, input logic [7:0] sw,
                         input logic [7:0] em, input logic [1:0] vc, input logic [1:0] pc);
        @(negedge clk);
        lane_cnt = cnt; swing_req = sw; emph_req = em;
        tx_swing_ceil = vc; tx_emph_ceil = pc; start = 1'b1;
        exp_q.push_back(model(cnt, sw, em, vc, pc));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        start = 1'b0;
        swing_req = 8'hFF; emph_req = 8'hFF; lane_cnt = 3'd4;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: samples 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (exp_q.size() != 0) begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " R10 done"}, {31'd0, done}, 32'd1);
                    check(t, lane_set, e);
                    last_exp = e;
                end else if (done) begin
                    check("R11 stray done", {31'd0, done}, 32'd0);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check("R1 reset lane_set", lane_set, 32'd0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        // R3: maximum across all four lanes, no saturation.
        issue("R3", 3'd4, 8'b00_01_00_01, 8'b00_00_01_00, 2'd3, 2'd3);
        idle(1);
        // R2: a high request on lane 3 is ignored with two active lanes.
        issue("R2", 3'd2, 8'b11_00_00_01, 8'b11_00_00_00, 2'd3, 2'd3);
        idle(1);
        check("R2 masked lane3", lane_set, 32'h01010101);
        // R2: no active lanes.
        issue("R2 zero lanes", 3'd0, 8'hFF, 8'hFF, 2'd3, 2'd3);
        idle(1);
        // R4: pre-emphasis above the ceiling is clamped and flagged.
        issue("R4", 3'd1, 8'h00, 8'h03, 2'd3, 2'd2);
        idle(1);
        // R4: exact equality also saturates.
        issue("R4 equal", 3'd1, 8'h00, 8'h01, 2'd3, 2'd1);
        idle(1);
        // R5: every pre-emphasis level with a generous swing ceiling.
        for (int pl = 0; pl < 4; pl++)
            issue("R5", 3'd4, 8'hFF, {6'd0, 2'(pl)}, 2'd3, 2'd3);
        idle(1);
        // R6: transmitter swing ceiling tighter than the budget.
        issue("R6", 3'd3, 8'b00_00_11_00, 8'h00, 2'd1, 2'd3);
        idle(1);
        // R7: swing equal to the ceiling saturates; below it does not.
        issue("R7 equal", 3'd1, 8'h02, 8'h00, 2'd2, 2'd3);
        issue("R7 below", 3'd1, 8'h01, 8'h00, 2'd2, 2'd3);
        idle(1);
        // R10: back-to-back strobes.
        issue("R10 b2b a", 3'd4, 8'h55, 8'h00, 2'd3, 2'd3);
        issue("R10 b2b b", 3'd4, 8'hAA, 8'h55, 2'd3, 2'd3);
        issue("R10 b2b c", 3'd2, 8'h0F, 8'h05, 2'd2, 2'd1);
        idle(4);
        // R11: result holds while the inputs change without a strobe.
        check("R11 hold", lane_set, last_exp);
        check("R11 done low", {31'd0, done}, 32'd0);

        // R8 and R9: sweep of pseudo-random patterns.
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue("R8 R9 sweep", 3'(lfsr[2:0] % 5), lfsr[10:3], {lfsr[4:0], lfsr[15:13]},
                  lfsr[12:11], lfsr[14:13]);
            if (lfsr[0]) idle(0);
        end
        idle(2);

        // R1: reset after activity.
        issue("R1 pre", 3'd4, 8'hFF, 8'h00, 2'd3, 2'd3);
        idle(1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset lane_set", lane_set, 32'd0);
        check("R1 mid reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule